// File: doc/BRIEF.md
# Gaussian Receptive Field Encoder Front End

This block turns one raw attribute sample into the set of arguments that a population of overlapping Gaussian receptive fields needs. The sample is first brought into the unit interval with min-max scaling, using a per-column minimum, maximum and a reciprocal of the range that are loaded as configuration. For each of the M fields it then forms the negative scaled squared distance between the scaled sample and that field's centre. The scale factor is the Gaussian term 1/(2σ²) with σ = 1/(k2·M), fixed when the block is built.

The M arguments leave in field order over a valid/ready stream to an external exponential evaluator. The evaluator hands back one result per field, tagged with the field number. Each result lands in a result buffer slot chosen by that tag, and a done pulse marks the point where all M slots of the current sample have been written. Centres come from the field index, the total field count and the tuning constant k1, and are held in a register bank. Two instances fed the same sample can be joined into one wider population: set the total field count and the base index of each instance, then concatenate their buffers.

All fixed-point words are 18 bits wide. The fraction width is a parameter (default 12, so 1.0 = 4096). Defaults: M = 4, 8-bit samples, k1 = 0.5, k2 = 1.5.

Top module: `grf_front_end`

## Requirements
- R1: After reset, busy, done and arg_valid are 0 and every slot of fire_times is 0.
- R2: The scaled sample is latched on an accepted start. It is 0 when cfg_max ≤ cfg_min (zero or inverted range) and 0 when sample ≤ cfg_min. It is 4096 when sample ≥ cfg_max. Otherwise it is min(4096, floor((sample − cfg_min)·cfg_recip / 2^8)), where cfg_recip is 2^20/(max − min) as an unsigned value.
- R3: Centre i equals ((i+1)·4096 − 2048)/4, that is 512, 1536, 2560 and 3584 for fields 0 to 3. A sample whose scaled value equals a centre gives argument 0 for that field.
- R4: With d = scaled sample − centre, the argument is −floor(floor(d²/4096)·73728/4096) as an 18-bit two's-complement value. Here 73728 is k2²·M²/2 = 18.0 in fixed point. Magnitudes of 2^17 or more saturate to −2^17. The argument is never positive.
- R5: One accepted start sends exactly M arguments, with arg_field running 0, 1, …, M−1. arg_valid is 0 whenever busy is 0.
- R6: While arg_valid is 1 and arg_ready is 0, arg_valid, arg_field and arg_value hold their values into the next cycle.
- R7: A result with res_valid = 1 while busy writes res_value into fire_times bits [18·res_field +: 18].
- R8: done is a one-cycle pulse that rises in the cycle after the M-th result write of the current sample. busy is 0 in that cycle.
- R9: A start asserted while busy is ignored: it launches no extra arguments and does not restart the field sequence.
- R10: A result with res_valid = 1 while not busy leaves fire_times unchanged.
- R11: Changing the sample input while busy does not change any argument of the sample in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the column configuration registers |
| cfg_min | input | DATA_W | Column minimum |
| cfg_max | input | DATA_W | Column maximum |
| cfg_recip | input | DATA_W+FRAC_W+1 | Reciprocal of the range, 2^(DATA_W+FRAC_W) scaled |
| start | input | 1 | Begin encoding the current sample (taken when idle) |
| sample | input | DATA_W | Raw attribute value |
| busy | output | 1 | A sample is being encoded |
| done | output | 1 | Pulse: all M results written |
| arg_valid | output | 1 | Argument available |
| arg_ready | input | 1 | Evaluator accepts the argument |
| arg_field | output | $clog2(NUM_FIELDS) | Field index of the argument |
| arg_value | output | 18 | Exponent argument, signed fixed point |
| res_valid | input | 1 | Evaluator result available |
| res_field | input | $clog2(NUM_FIELDS) | Field index of the result |
| res_value | input | 18 | Evaluated firing value |
| fire_times | output | NUM_FIELDS*18 | Result buffer, slot i at bits [18·i +: 18] |

## Verification
The bench aims at the scaling edges: a sample at, below and above the column limits, a zero range and an inverted range, and a range of one. A wrong clamp or a missing zero-range guard would give arguments from a wrapped or huge scaled value. Samples that land exactly on each centre must give argument 0; an off-by-one centre formula gives a small negative value instead. A randomly stalling ready checks that the field order and held values survive back-pressure. Start pulses and sample changes in mid-flight check that nothing restarts and that the latched value is kept. Stray results while idle must not change the buffer, and a design that wrote them anyway would corrupt the last sample's firing times.

// File: rtl/grf_pkg.sv
package grf_pkg;

    localparam int WORD_W     = 18;
    localparam int MAX_FIELDS = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    // Result record coming back from the evaluator
    typedef struct packed {
        logic [3:0]        field;
        logic [WORD_W-1:0] value;
    } grf_rec_t;

    // Centre of global field idx: ((idx+1)*ONE - k1) / total
    function automatic longint centre_q(int idx, int total, int frac_w, longint k1_q);
        return (((longint'(idx) + 1) <<< frac_w) - k1_q) / longint'(total);
    endfunction

    // 1/(2*sigma^2) with sigma = 1/(k2*M): k2^2 * M^2 / 2 in fixed point
    function automatic longint scale_q(int total, int frac_w, longint k2_q);
        return (k2_q * k2_q * longint'(total) * longint'(total)) >>> (frac_w + 1);
    endfunction

endpackage

// File: rtl/grf_normalizer.sv
module grf_normalizer #(
    parameter int DATA_W = 8,
    parameter int FRAC_W = 12,
    localparam int RW    = DATA_W + FRAC_W + 1,
    localparam int PW    = DATA_W + RW
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    input  logic [RW-1:0]     recip,
    output logic [FRAC_W:0]   norm
);
    localparam logic [FRAC_W:0] ONE = {1'b1, {FRAC_W{1'b0}}};

    logic [DATA_W-1:0] diff;
    logic [PW-1:0]     prod;
    logic [PW-1:0]     scaled;

    always_comb begin
        diff   = sample - lo;
        prod   = PW'(diff) * PW'(recip);
        scaled = prod >> DATA_W;
        if (hi <= lo)                norm = '0;   // empty or inverted range
        else if (sample <= lo)       norm = '0;
        else if (sample >= hi)       norm = ONE;
        else if (scaled > PW'(ONE))  norm = ONE;
        else                         norm = scaled[FRAC_W:0];
    end
endmodule

// File: rtl/grf_centre_bank.sv
module grf_centre_bank #(
    parameter int NUM_FIELDS   = 4,
    parameter int TOTAL_FIELDS = NUM_FIELDS,
    parameter int FIELD_BASE   = 0,
    parameter int FRAC_W       = 12,
    parameter int K1_Q         = 2048,
    localparam int IW          = $clog2(NUM_FIELDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IW-1:0]   sel,
    output logic [FRAC_W:0] centre
);
    import grf_pkg::*;

    logic [FRAC_W:0] bank [NUM_FIELDS];

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_slot
        localparam logic [FRAC_W:0] CVAL =
            (FRAC_W+1)'(centre_q(FIELD_BASE + i, TOTAL_FIELDS, FRAC_W, longint'(K1_Q)));
        logic [FRAC_W:0] c_q;
        always_ff @(posedge clk) begin
            if (rst) c_q <= CVAL;
        end
        assign bank[i] = c_q;
    end

    assign centre = bank[sel];
endmodule

// File: rtl/grf_arg_unit.sv
module grf_arg_unit #(
    parameter int     FRAC_W = 12,
    parameter longint SCALE  = 73728,
    parameter int     WORD_W = 18
) (
    input  logic [FRAC_W:0]   norm,
    input  logic [FRAC_W:0]   centre,
    output logic [WORD_W-1:0] arg
);
    localparam int DW   = FRAC_W + 2;
    localparam int PWID = FRAC_W + 1 + 32;
    localparam logic [31:0]   SC    = 32'(SCALE);
    localparam logic [PWID-1:0] LIMIT = PWID'(1) << (WORD_W - 1);

    logic signed [DW-1:0] d;
    logic [DW-1:0]        mag;
    logic [2*DW-1:0]      sq_full;
    logic [FRAC_W:0]      sq;
    logic [PWID-1:0]      pf;
    logic [PWID-1:0]      pq;

    always_comb begin
        d       = $signed({1'b0, norm}) - $signed({1'b0, centre});
        mag     = d[DW-1] ? DW'(-d) : DW'(d);
        sq_full = (2*DW)'(mag) * (2*DW)'(mag);        // squaring multiply
        sq      = (FRAC_W+1)'(sq_full >> FRAC_W);
        pf      = PWID'(sq) * PWID'(SC);              // scaling multiply
        pq      = pf >> FRAC_W;
        if (pq >= LIMIT) arg = {1'b1, {(WORD_W-1){1'b0}}};
        else             arg = WORD_W'(0) - WORD_W'(pq);
    end
endmodule

// File: rtl/grf_result_buffer.sv
module grf_result_buffer
    import grf_pkg::*;
#(
    parameter int NUM_FIELDS = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  grf_rec_t                     wr_rec,
    output logic [NUM_FIELDS*WORD_W-1:0] flat
);
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_slot
        logic [WORD_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst)                                 slot_q <= '0;
            else if (wr_en && wr_rec.field == 4'(i)) slot_q <= wr_rec.value;
        end
        assign flat[i*WORD_W +: WORD_W] = slot_q;
    end
endmodule

// File: rtl/grf_front_end.sv
module grf_front_end
    import grf_pkg::*;
#(
    parameter int NUM_FIELDS   = 4,
    parameter int TOTAL_FIELDS = NUM_FIELDS,
    parameter int FIELD_BASE   = 0,
    parameter int DATA_W       = 8,
    parameter int FRAC_W       = 12,
    parameter int K1_Q         = 2048,
    parameter int K2_Q         = 6144,
    localparam int IW          = $clog2(NUM_FIELDS),
    localparam int RW          = DATA_W + FRAC_W + 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [DATA_W-1:0]            cfg_min,
    input  logic [DATA_W-1:0]            cfg_max,
    input  logic [RW-1:0]                cfg_recip,
    input  logic                         start,
    input  logic [DATA_W-1:0]            sample,
    output logic                         busy,
    output logic                         done,
    output logic                         arg_valid,
    input  logic                         arg_ready,
    output logic [IW-1:0]                arg_field,
    output logic [WORD_W-1:0]            arg_value,
    input  logic                         res_valid,
    input  logic [IW-1:0]                res_field,
    input  logic [WORD_W-1:0]            res_value,
    output logic [NUM_FIELDS*WORD_W-1:0] fire_times
);
    localparam longint          SCALE = scale_q(TOTAL_FIELDS, FRAC_W, longint'(K2_Q));
    localparam logic [IW-1:0]   LAST  = IW'(NUM_FIELDS - 1);
    localparam logic [FRAC_W:0] ONE   = {1'b1, {FRAC_W{1'b0}}};

    seq_state_e        state_q;
    logic [DATA_W-1:0] lo_q, hi_q;
    logic [RW-1:0]     rcp_q;
    logic [FRAC_W:0]   norm_c, norm_q, centre;
    logic [IW-1:0]     fld_q, cnt_q;
    logic              done_q, wr_en;
    grf_rec_t          wr_rec;

    grf_normalizer #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_norm (
        .sample(sample), .lo(lo_q), .hi(hi_q), .recip(rcp_q), .norm(norm_c)
    );

    grf_centre_bank #(
        .NUM_FIELDS(NUM_FIELDS), .TOTAL_FIELDS(TOTAL_FIELDS), .FIELD_BASE(FIELD_BASE),
        .FRAC_W(FRAC_W), .K1_Q(K1_Q)
    ) u_centres (
        .clk(clk), .rst(rst), .sel(fld_q), .centre(centre)
    );

    grf_arg_unit #(.FRAC_W(FRAC_W), .SCALE(SCALE), .WORD_W(WORD_W)) u_arg (
        .norm(norm_q), .centre(centre), .arg(arg_value)
    );

    assign wr_en        = res_valid && (state_q != ST_IDLE);
    assign wr_rec.field = 4'(res_field);
    assign wr_rec.value = res_value;

    grf_result_buffer #(.NUM_FIELDS(NUM_FIELDS)) u_buf (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_rec(wr_rec), .flat(fire_times)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lo_q    <= '0;
            hi_q    <= '0;
            rcp_q   <= '0;
            norm_q  <= '0;
            fld_q   <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (cfg_we) begin
                lo_q  <= cfg_min;
                hi_q  <= cfg_max;
                rcp_q <= cfg_recip;
            end
            case (state_q)
                ST_IDLE: if (start) begin
                    norm_q  <= norm_c;
                    fld_q   <= '0;
                    cnt_q   <= '0;
                    state_q <= ST_SEND;
                end
                ST_SEND: if (arg_ready) begin
                    if (fld_q == LAST) state_q <= ST_WAIT;
                    else               fld_q   <= fld_q + 1'b1;
                end
                default: ;
            endcase
            if (wr_en) begin
                if (cnt_q == LAST) begin
                    cnt_q   <= '0;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign arg_valid = (state_q == ST_SEND);
    assign arg_field = fld_q;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !arg_valid);                                            // R5
    AST_FIELD_STEP: assert property (@(posedge clk) disable iff (rst)
        (arg_valid && arg_ready && arg_field != LAST)
        |=> (arg_valid && arg_field == IW'($past(arg_field) + 1'b1)));    // R5
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (arg_valid && !arg_ready)
        |=> (arg_valid && $stable(arg_field) && $stable(arg_value)));     // R6
    AST_ARG_NONPOS: assert property (@(posedge clk) disable iff (rst)
        arg_valid |-> (arg_value[WORD_W-1] || arg_value == '0));          // R4
    AST_NORM_CAP: assert property (@(posedge clk) disable iff (rst)
        busy |-> (norm_q <= ONE));                                        // R2
    AST_LATCH_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(norm_q));                                        // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                  // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                                  // R8
endmodule

// File: tb/test_grf_front_end.sv
module test_grf_front_end;
    localparam int M  = 4;
    localparam int DW = 8;
    localparam int RW = 21;
    localparam int W  = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [DW-1:0] cfg_min = '0, cfg_max = '0;
    logic [RW-1:0] cfg_recip = '0;
    logic start = 1'b0;
    logic [DW-1:0] sample = '0;
    logic busy, done, arg_valid;
    logic arg_ready = 1'b0;
    logic [1:0] arg_field;
    logic [W-1:0] arg_value;
    logic res_valid = 1'b0;
    logic [1:0] res_field = '0;
    logic [W-1:0] res_value = '0;
    logic [M*W-1:0] fire_times;

    int vectors = 0;
    int fails   = 0;
    int b_lo = 0, b_hi = 0, b_rc = 0;
    logic [W-1:0] exp_buf [M];

    always #2 clk = ~clk;   // 250 MHz

    grf_front_end i_grf_front_end (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_min(cfg_min), .cfg_max(cfg_max),
        .cfg_recip(cfg_recip), .start(start), .sample(sample), .busy(busy), .done(done),
        .arg_valid(arg_valid), .arg_ready(arg_ready), .arg_field(arg_field),
        .arg_value(arg_value), .res_valid(res_valid), .res_field(res_field),
        .res_value(res_value), .fire_times(fire_times)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // R2 scaling rule
    function automatic int exp_norm(int v);
        int t;
        if (b_hi <= b_lo) return 0;
        if (v <= b_lo)    return 0;
        if (v >= b_hi)    return 4096;
        t = ((v - b_lo) * b_rc) >>> 8;
        return (t > 4096) ? 4096 : t;
    endfunction

    // R3 centres, R4 argument (k2 = 1.5, M = 4 -> scale 18.0 = 73728)
    function automatic logic [W-1:0] exp_arg(int norm, int idx);
        int d, sq;
        longint p;
        d  = norm - ((idx + 1) * 4096 - 2048) / 4;
        sq = (d * d) >>> 12;
        p  = (longint'(sq) * 73728) >>> 12;
        if (p >= 131072) return 18'h20000;
        return W'(-p);
    endfunction

    task automatic load_cfg(input int lo, input int hi, input int rc);
        @(negedge clk);
        cfg_min = DW'(lo); cfg_max = DW'(hi); cfg_recip = RW'(rc); cfg_we = 1'b1;
        b_lo = lo; b_hi = hi; b_rc = rc;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_sample(input int v, input bit glitch, input string tag);
        int n_args = 0, cyc = 0, head = 0, tail = 0, guard = 0;
        int pfield [8];
        int pdue [8];
        int nrm;
        bit prev_wait = 0, rdy;
        logic [1:0] hold_f;
        logic [W-1:0] hold_v;
        nrm = exp_norm(v);
        @(negedge clk);
        sample = DW'(v); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (1) begin
            if (done === 1'b1) begin
                res_valid = 1'b0;
                break;
            end
            if (prev_wait) begin
                check("R6", "stalled valid", 64'(arg_valid), 64'(1));
                check("R6", "stalled field", 64'(arg_field), 64'(hold_f));
                check("R6", "stalled value", 64'(arg_value), 64'(hold_v));
            end
            if (head < tail && pdue[head] <= cyc) begin
                res_valid = 1'b1;
                res_field = 2'(pfield[head]);
                res_value = W'($urandom);
                exp_buf[pfield[head]] = res_value;
                head++;
            end else begin
                res_valid = 1'b0;
            end
            if (arg_valid === 1'b1) begin
                rdy = ($urandom % 3) != 0;
                if (rdy) begin
                    check("R5", "field order", 64'(arg_field), 64'(n_args));
                    check(tag, $sformatf("argument field %0d", n_args),
                          64'(arg_value), 64'(exp_arg(nrm, n_args)));
                    pfield[tail] = n_args;
                    pdue[tail]   = cyc + 2;
                    tail++;
                    n_args++;
                end
                prev_wait = !rdy;
                hold_f = arg_field;
                hold_v = arg_value;
                arg_ready = rdy;
            end else begin
                prev_wait = 0;
                arg_ready = 1'(($urandom % 2));
            end
            // R9/R11: poke start and the sample while busy
            start = glitch && (n_args >= 1) && (n_args < M);
            if (glitch) sample = ~DW'(v);
            @(negedge clk);
            cyc++;
            guard++;
            if (guard > 200) begin
                check("R8", "done timeout", 64'(0), 64'(1));
                break;
            end
        end
        start = 1'b0;
        arg_ready = 1'b0;
        check("R8", "busy low with done", 64'(busy), 64'(0));
        check("R9", "argument count", 64'(n_args), 64'(M));
        for (int i = 0; i < M; i++)
            check("R7", $sformatf("buffer slot %0d", i),
                  64'(fire_times[i*W +: W]), 64'(exp_buf[i]));
        @(negedge clk);
        check("R8", "done single cycle", 64'(done), 64'(0));
        check("R9", "no relaunch", 64'(arg_valid), 64'(0));
    endtask

    task automatic stray_result;
        logic [M*W-1:0] snap;
        snap = fire_times;
        @(negedge clk);
        res_valid = 1'b1; res_field = 2'd2; res_value = W'($urandom);
        @(negedge clk);
        res_valid = 1'b0;
        @(negedge clk);
        check("R10", "idle result ignored", 64'(fire_times), 64'(snap));
    endtask

    initial begin
        void'($urandom(32'd51966));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "busy after reset", 64'(busy), 64'(0));
        check("R1", "done after reset", 64'(done), 64'(0));
        check("R1", "valid after reset", 64'(arg_valid), 64'(0));
        check("R1", "buffer after reset", 64'(fire_times), 64'(0));
        stray_result();

        // R3: samples that land exactly on each centre
        load_cfg(0, 8, 131072);
        for (int k = 0; k < M; k++) run_sample(2*k + 1, 0, "R3");

        // R2: limits of a normal range
        load_cfg(20, 200, 1048576 / 180);
        run_sample(20, 0, "R2");
        run_sample(10, 0, "R2");
        run_sample(200, 0, "R2");
        run_sample(255, 0, "R2");
        run_sample(111, 0, "R2");
        // R2: zero, inverted and unit ranges
        load_cfg(50, 50, 0);
        run_sample(70, 0, "R2");
        load_cfg(90, 40, 0);
        run_sample(60, 0, "R2");
        load_cfg(100, 101, 1048576);
        run_sample(101, 0, "R2");
        run_sample(100, 0, "R2");

        // R9/R11: start and sample changes in mid-flight
        load_cfg(5, 250, 1048576 / 245);
        run_sample(77, 1, "R11");
        run_sample(200, 1, "R11");

        // Random configurations and samples
        for (int n = 0; n < 40; n++) begin
            if (n % 5 == 0) begin
                int lo, span;
                lo   = $urandom % 100;
                span = 1 + $urandom % 150;
                load_cfg(lo, lo + span, 1048576 / span);
            end
            run_sample($urandom % 256, 1'($urandom % 2), "R4");
        end
        stray_result();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule